// File: doc/BRIEF.md
# Table-Based Page Translation Unit

This block sits between a main processor and physical memory and turns each logical address into a physical one. The upper part of the logical address selects an entry in a mapping table held in on-chip storage. That entry supplies a physical page number and a present flag. The in-page offset goes through unchanged. A second, separate table keeps a referenced bit and a dirty bit for every logical page. These bits are updated on the same clock edge that accepts a translated access.

When the processor touches a page whose present flag is clear, no physical access is issued. Instead the unit raises a page-fault output and records the page number that faulted. The fault stays up, and new processor requests are held off, until a helper agent acknowledges it. The helper agent also owns a maintenance port. Through that port it can read a page's mapping and status, rewrite a mapping, and clear status bits. In any cycle where both sides request, the maintenance port wins over the processor.

With default parameters the logical space is 8 MiB in 4 KiB pages, which gives 2048 pages. Physical page numbers are 8 bits wide.

Top module: `page_xlate_unit`

## Requirements
- R1: One cycle after an accepted access to a present page, `phys_addr` holds the entry's physical page number above the untouched low `OFFS_W` logical address bits.
- R2: `phys_en` pulses for exactly one cycle, and only after an accepted access to a present page. `phys_we` follows the accepted `cpu_we` in that cycle.
- R3: An accepted access to a non-present page raises `fault` in the next cycle and loads `fault_lpn` with the logical page number. No `phys_en` is produced for it.
- R4: `fault` stays high until `fault_ack` is sampled high. While it is high, `cpu_ready` is low and processor requests are not accepted.
- R5: An accepted read sets the page's referenced bit and leaves its dirty bit unchanged.
- R6: An accepted write sets both the referenced bit and the dirty bit of the page. Status bits stay set until they are cleared through the maintenance port.
- R7: When `maint_req` is high, `cpu_ready` is low. A processor request in that cycle is ignored: it produces no `phys_en` and does not change any status bit.
- R8: Maintenance op encodings are 0 = read, 1 = write mapping, 2 = clear status, 3 = read then clear. A read op sets `maint_rvalid` in the next cycle. `maint_rdata` then carries referenced at bit PPN_W+2, dirty at bit PPN_W+1, present at bit PPN_W and the physical page number below that. A mapping write takes the present flag from `maint_wdata[PPN_W]` and the page number from the bits below it.
- R9: A clear op zeroes both status bits of the page. A read-then-clear op returns the bits as they were before the clear and leaves them zero afterwards.
- R10: After reset every page is non-present with both status bits zero, and `phys_en`, `fault` and `maint_rvalid` are low.
- R11: An access that faults leaves the status bits of its page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | LA_W | Logical address |
| cpu_ready | output | 1 | Request is accepted this cycle when high |
| phys_en | output | 1 | Physical access strobe, one cycle |
| phys_we | output | 1 | Physical access is a write |
| phys_addr | output | PPN_W+OFFS_W | Translated physical address |
| fault | output | 1 | Page fault pending |
| fault_lpn | output | LA_W-OFFS_W | Logical page number that faulted |
| fault_ack | input | 1 | Helper acknowledges the pending fault |
| maint_req | input | 1 | Maintenance operation request |
| maint_op | input | 2 | Maintenance operation code |
| maint_lpn | input | LA_W-OFFS_W | Logical page addressed by maintenance |
| maint_wdata | input | PPN_W+1 | Present flag and physical page for a mapping write |
| maint_rvalid | output | 1 | Maintenance read data valid |
| maint_rdata | output | PPN_W+3 | Status bits, present flag and physical page |

## Verification
The bench maps a small 16-page configuration with a computed pattern of present and absent pages, then sweeps every page with reads and writes at varying offsets. A design that garbled the offset or picked the wrong table entry would show a wrong `phys_addr`. One that let a missing page through would pulse `phys_en` where a fault belongs. Status bits are read back after every phase, which exposes a dirty bit set by reads, a fault that marks a page referenced, and a read-then-clear that returns the cleared value. Simultaneous processor and maintenance requests check that the processor request is actually dropped, and a fault held for several idle cycles catches a fault output that clears itself without an acknowledge.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    MOP_READ     = 2'd0,
    MOP_MAP_WR   = 2'd1,
    MOP_ACC_CLR  = 2'd2,
    MOP_READ_CLR = 2'd3
  } maint_op_e;
endpackage

// File: rtl/pxu_rst_sync.sv
module pxu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/pxu_map_table.sv
module pxu_map_table #(
  parameter int LPN_W = 11,
  parameter int PPN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LPN_W-1:0] wr_lpn,
  input  logic             wr_present,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [LPN_W-1:0] a_lpn,
  output logic             a_present,
  output logic [PPN_W-1:0] a_ppn,
  input  logic [LPN_W-1:0] b_lpn,
  output logic             b_present,
  output logic [PPN_W-1:0] b_ppn
);
  localparam int NPAGES = 1 << LPN_W;

  logic [NPAGES-1:0] present_q;
  logic [PPN_W-1:0]  ppn_mem [NPAGES];

  // present flags need a defined reset value; page numbers do not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= '0;
    end else if (wr_en) begin
      present_q[wr_lpn] <= wr_present;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ppn_mem[wr_lpn] <= wr_ppn;
    end
  end

  assign a_present = present_q[a_lpn];
  assign a_ppn     = ppn_mem[a_lpn];
  assign b_present = present_q[b_lpn];
  assign b_ppn     = ppn_mem[b_lpn];
endmodule

// File: rtl/pxu_acc_table.sv
module pxu_acc_table #(
  parameter int LPN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LPN_W-1:0] set_lpn,
  input  logic             set_dirty,
  input  logic             clr_en,
  input  logic [LPN_W-1:0] clr_lpn,
  input  logic [LPN_W-1:0] rd_lpn,
  output logic             rd_ref,
  output logic             rd_dirty
);
  localparam int NPAGES = 1 << LPN_W;

  logic [NPAGES-1:0] ref_vec;
  logic [NPAGES-1:0] dirty_vec;

  for (genvar g = 0; g < NPAGES; g++) begin : g_ent
    localparam logic [LPN_W-1:0] IDX = LPN_W'(g);
    logic set_hit;
    logic clr_hit;
    logic upd;
    logic ref_d;
    logic dirty_d;
    logic ref_q;
    logic dirty_q;

    assign set_hit = set_en && (set_lpn == IDX);
    assign clr_hit = clr_en && (clr_lpn == IDX);
    assign upd     = set_hit || clr_hit;

    always_comb begin
      ref_d   = ref_q;
      dirty_d = dirty_q;
      if (clr_hit) begin
        ref_d   = 1'b0;
        dirty_d = 1'b0;
      end
      if (set_hit) begin
        ref_d = 1'b1;
        if (set_dirty) begin
          dirty_d = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q   <= 1'b0;
        dirty_q <= 1'b0;
      end else if (upd) begin
        ref_q   <= ref_d;
        dirty_q <= dirty_d;
      end
    end

    assign ref_vec[g]   = ref_q;
    assign dirty_vec[g] = dirty_q;
  end

  assign rd_ref   = ref_vec[rd_lpn];
  assign rd_dirty = dirty_vec[rd_lpn];
endmodule

// File: rtl/pxu_fault_ctl.sv
module pxu_fault_ctl #(
  parameter int LPN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise,
  input  logic [LPN_W-1:0] raise_lpn,
  input  logic             ack,
  output logic             pending,
  output logic [LPN_W-1:0] pending_lpn
);
  logic             pend_d;
  logic             pend_q;
  logic [LPN_W-1:0] lpn_q;

  always_comb begin
    pend_d = pend_q;
    if (raise) begin
      pend_d = 1'b1;
    end else if (ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lpn_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (raise) begin
        lpn_q <= raise_lpn;
      end
    end
  end

  assign pending     = pend_q;
  assign pending_lpn = lpn_q;
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int LA_W   = 23,
  parameter int OFFS_W = 12,
  parameter int PPN_W  = 8,
  localparam int LPN_W = LA_W - OFFS_W,
  localparam int PA_W  = PPN_W + OFFS_W,
  localparam int RD_W  = PPN_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [LA_W-1:0]  cpu_addr,
  output logic             cpu_ready,
  output logic             phys_en,
  output logic             phys_we,
  output logic [PA_W-1:0]  phys_addr,
  output logic             fault,
  output logic [LPN_W-1:0] fault_lpn,
  input  logic             fault_ack,
  input  logic             maint_req,
  input  logic [1:0]       maint_op,
  input  logic [LPN_W-1:0] maint_lpn,
  input  logic [PPN_W:0]   maint_wdata,
  output logic             maint_rvalid,
  output logic [RD_W-1:0]  maint_rdata
);
  logic rst_sync_n;

  pxu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // processor side decode
  logic [LPN_W-1:0]  cpu_lpn;
  logic [OFFS_W-1:0] cpu_off;
  logic              cpu_acc;
  logic              cpu_hit;
  logic              cpu_miss;
  logic              cpu_present;
  logic [PPN_W-1:0]  cpu_ppn;

  assign cpu_lpn   = cpu_addr[LA_W-1:OFFS_W];
  assign cpu_off   = cpu_addr[OFFS_W-1:0];
  assign cpu_ready = !maint_req && !fault;
  assign cpu_acc   = cpu_req && cpu_ready;
  assign cpu_hit   = cpu_acc && cpu_present;
  assign cpu_miss  = cpu_acc && !cpu_present;

  // maintenance decode
  maint_op_e        mop;
  logic             m_rd;
  logic             m_clr;
  logic             m_wr;
  logic             m_present;
  logic [PPN_W-1:0] m_ppn;
  logic             m_ref;
  logic             m_dirty;

  assign mop   = maint_op_e'(maint_op);
  assign m_rd  = maint_req && ((mop == MOP_READ) || (mop == MOP_READ_CLR));
  assign m_clr = maint_req && ((mop == MOP_ACC_CLR) || (mop == MOP_READ_CLR));
  assign m_wr  = maint_req && (mop == MOP_MAP_WR);

  pxu_map_table #(
    .LPN_W (LPN_W),
    .PPN_W (PPN_W)
  ) u_map (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (m_wr),
    .wr_lpn     (maint_lpn),
    .wr_present (maint_wdata[PPN_W]),
    .wr_ppn     (maint_wdata[PPN_W-1:0]),
    .a_lpn      (cpu_lpn),
    .a_present  (cpu_present),
    .a_ppn      (cpu_ppn),
    .b_lpn      (maint_lpn),
    .b_present  (m_present),
    .b_ppn      (m_ppn)
  );

  pxu_acc_table #(
    .LPN_W (LPN_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_en    (cpu_hit),
    .set_lpn   (cpu_lpn),
    .set_dirty (cpu_we),
    .clr_en    (m_clr),
    .clr_lpn   (maint_lpn),
    .rd_lpn    (maint_lpn),
    .rd_ref    (m_ref),
    .rd_dirty  (m_dirty)
  );

  pxu_fault_ctl #(
    .LPN_W (LPN_W)
  ) u_fault (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .raise       (cpu_miss),
    .raise_lpn   (cpu_lpn),
    .ack         (fault_ack),
    .pending     (fault),
    .pending_lpn (fault_lpn)
  );

  // output stage: next-state
  logic             phys_en_d;
  logic             phys_we_d;
  logic [PA_W-1:0]  phys_addr_d;
  logic             rvalid_d;
  logic [RD_W-1:0]  rdata_d;

  always_comb begin
    phys_en_d   = cpu_hit;
    phys_we_d   = cpu_hit && cpu_we;
    phys_addr_d = {cpu_ppn, cpu_off};
    rvalid_d    = m_rd;
    rdata_d     = {m_ref, m_dirty, m_present, m_ppn};
  end

  // output stage: registers
  logic             phys_en_q;
  logic             phys_we_q;
  logic [PA_W-1:0]  phys_addr_q;
  logic             rvalid_q;
  logic [RD_W-1:0]  rdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phys_en_q   <= 1'b0;
      phys_we_q   <= 1'b0;
      phys_addr_q <= '0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
    end else begin
      phys_en_q <= phys_en_d;
      phys_we_q <= phys_we_d;
      rvalid_q  <= rvalid_d;
      if (cpu_hit) begin
        phys_addr_q <= phys_addr_d;
      end
      if (m_rd) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign phys_en      = phys_en_q;
  assign phys_we      = phys_we_q;
  assign phys_addr    = phys_addr_q;
  assign maint_rvalid = rvalid_q;
  assign maint_rdata  = rdata_q;
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
  parameter int LA_W   = 23,
  parameter int OFFS_W = 12,
  parameter int PPN_W  = 8,
  localparam int LPN_W = LA_W - OFFS_W,
  localparam int PA_W  = PPN_W + OFFS_W
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic [LA_W-1:0]  cpu_addr,
  input logic             cpu_ready,
  input logic             phys_en,
  input logic             phys_we,
  input logic [PA_W-1:0]  phys_addr,
  input logic             fault,
  input logic             fault_ack,
  input logic             maint_req,
  input logic [1:0]       maint_op
);
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_en |-> phys_addr[OFFS_W-1:0] == $past(cpu_addr[OFFS_W-1:0])); // R1

  AST_PHYS_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_en |-> $past(cpu_req && cpu_ready)); // R2

  AST_PHYS_WE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_en |-> phys_we == $past(cpu_we)); // R2

  AST_FAULT_NO_PHYS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(fault && phys_en)); // R3

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fault && !fault_ack) |=> fault); // R4

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault |-> !cpu_ready); // R4

  AST_MAINT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    maint_req |-> !cpu_ready); // R7
endmodule

bind page_xlate_unit pxu_checker #(
  .LA_W   (LA_W),
  .OFFS_W (OFFS_W),
  .PPN_W  (PPN_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_addr   (cpu_addr),
  .cpu_ready  (cpu_ready),
  .phys_en    (phys_en),
  .phys_we    (phys_we),
  .phys_addr  (phys_addr),
  .fault      (fault),
  .fault_ack  (fault_ack),
  .maint_req  (maint_req),
  .maint_op   (maint_op)
);

// File: tb/page_xlate_unit_tb.sv
`timescale 1ns/1ps
module page_xlate_unit_tb;
  localparam int LA_W   = 16;
  localparam int OFFS_W = 12;
  localparam int PPN_W  = 8;
  localparam int LPN_W  = LA_W - OFFS_W;
  localparam int NPAGES = 1 << LPN_W;
  localparam int PA_W   = PPN_W + OFFS_W;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we;
  logic [LA_W-1:0] cpu_addr;
  logic cpu_ready, phys_en, phys_we, fault, fault_ack;
  logic [PA_W-1:0] phys_addr;
  logic [LPN_W-1:0] fault_lpn, maint_lpn;
  logic maint_req, maint_rvalid;
  logic [1:0] maint_op;
  logic [PPN_W:0] maint_wdata;
  logic [PPN_W+2:0] maint_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  page_xlate_unit #(.LA_W(LA_W), .OFFS_W(OFFS_W), .PPN_W(PPN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .phys_en(phys_en),
    .phys_we(phys_we), .phys_addr(phys_addr), .fault(fault),
    .fault_lpn(fault_lpn), .fault_ack(fault_ack), .maint_req(maint_req),
    .maint_op(maint_op), .maint_lpn(maint_lpn), .maint_wdata(maint_wdata),
    .maint_rvalid(maint_rvalid), .maint_rdata(maint_rdata)
  );

  function automatic bit exp_present(int i);
    return (i % 3) != 0;
  endfunction

  function automatic logic [PPN_W-1:0] exp_ppn(int i);
    return PPN_W'((i * 37 + 5) % 256);
  endfunction

  function automatic logic [OFFS_W-1:0] offs_of(int i, int salt);
    return OFFS_W'((i * 291 + salt * 1013 + 7) % 4096);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // drives an access at a falling edge; outputs are sampled one cycle later
  task automatic cpu_access(logic [LA_W-1:0] addr, logic we);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic maint(logic [1:0] op, int lpn, logic [PPN_W:0] wd);
    @(negedge clk);
    maint_req = 1'b1; maint_op = op; maint_lpn = LPN_W'(lpn); maint_wdata = wd;
    @(negedge clk);
    maint_req = 1'b0;
  endtask

  task automatic ack_fault();
    @(negedge clk);
    fault_ack = 1'b1;
    @(negedge clk);
    fault_ack = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; fault_ack = 0;
    maint_req = 0; maint_op = 0; maint_lpn = '0; maint_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(!phys_en && !fault && !maint_rvalid, "R10 outputs", {phys_en, fault, maint_rvalid}, 0);
    for (int i = 0; i < NPAGES; i++) begin
      maint(2'd0, i, '0);
      check(maint_rdata[PPN_W+2:PPN_W] == 3'b000, "R10 table", maint_rdata[PPN_W+2:PPN_W], 0);
    end

    // map all pages, then read back (R8)
    for (int i = 0; i < NPAGES; i++) maint(2'd1, i, {exp_present(i), exp_ppn(i)});
    for (int i = 0; i < NPAGES; i++) begin
      maint(2'd0, i, '0);
      check(maint_rvalid, "R8 rvalid", maint_rvalid, 1);
      check(maint_rdata == {2'b00, exp_present(i), exp_ppn(i)}, "R8 rdata",
            maint_rdata, {2'b00, exp_present(i), exp_ppn(i)});
    end

    // read sweep over every page
    for (int i = 0; i < NPAGES; i++) begin
      logic [OFFS_W-1:0] off;
      off = offs_of(i, 0);
      cpu_access({LPN_W'(i), off}, 1'b0);
      if (exp_present(i)) begin
        check(phys_en && !phys_we && !fault, "R2 read strobe", {phys_en, phys_we, fault}, 3'b100);
        check(phys_addr == {exp_ppn(i), off}, "R1 translate", phys_addr, {exp_ppn(i), off});
        @(negedge clk);
        check(!phys_en, "R2 single pulse", phys_en, 0);
      end else begin
        check(!phys_en && fault, "R3 fault raised", {phys_en, fault}, 2'b01);
        check(fault_lpn == LPN_W'(i), "R3 fault lpn", fault_lpn, i);
        check(!cpu_ready, "R4 ready low", cpu_ready, 0);
        cpu_access({LPN_W'((i + 1) % NPAGES), off}, 1'b1);
        check(!phys_en && fault, "R4 request held off", {phys_en, fault}, 2'b01);
        repeat (2) @(negedge clk);
        check(fault, "R4 fault holds", fault, 1);
        ack_fault();
        check(!fault && cpu_ready, "R4 ack clears", {fault, cpu_ready}, 2'b01);
      end
    end

    // R5 / R11: reads set only referenced; faults set nothing
    for (int i = 0; i < NPAGES; i++) begin
      maint(2'd0, i, '0);
      check(maint_rdata[PPN_W+2:PPN_W+1] == {exp_present(i), 1'b0}, "R5 R11 status",
            maint_rdata[PPN_W+2:PPN_W+1], {exp_present(i), 1'b0});
    end

    // clear all, then write to even present pages
    for (int i = 0; i < NPAGES; i++) maint(2'd2, i, '0);
    for (int i = 0; i < NPAGES; i += 2) begin
      logic [OFFS_W-1:0] off;
      off = offs_of(i, 1);
      cpu_access({LPN_W'(i), off}, 1'b1);
      if (exp_present(i)) begin
        check(phys_en && phys_we, "R2 write strobe", {phys_en, phys_we}, 2'b11);
        check(phys_addr == {exp_ppn(i), off}, "R1 write translate", phys_addr, {exp_ppn(i), off});
      end else begin
        ack_fault();
      end
    end
    for (int i = 0; i < NPAGES; i++) begin
      bit w;
      w = exp_present(i) && (i % 2 == 0);
      maint(2'd0, i, '0);
      check(maint_rdata[PPN_W+2:PPN_W+1] == {w, w}, "R6 R9 status",
            maint_rdata[PPN_W+2:PPN_W+1], {w, w});
    end

    // R9 read-then-clear
    maint(2'd3, 2, '0);
    check(maint_rdata[PPN_W+2:PPN_W+1] == 2'b11, "R9 old value", maint_rdata[PPN_W+2:PPN_W+1], 3);
    maint(2'd0, 2, '0);
    check(maint_rdata[PPN_W+2:PPN_W+1] == 2'b00, "R9 cleared", maint_rdata[PPN_W+2:PPN_W+1], 0);

    // R6 stickiness: a read after a write keeps dirty
    cpu_access({LPN_W'(4), 12'h010}, 1'b1);
    cpu_access({LPN_W'(4), 12'h020}, 1'b0);
    maint(2'd0, 4, '0);
    check(maint_rdata[PPN_W+2:PPN_W+1] == 2'b11, "R6 sticky", maint_rdata[PPN_W+2:PPN_W+1], 3);

    // R7 priority: simultaneous processor and maintenance requests
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = {LPN_W'(1), 12'h345};
    maint_req = 1'b1; maint_op = 2'd0; maint_lpn = LPN_W'(7);
    #1;
    check(!cpu_ready, "R7 ready low", cpu_ready, 0);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; maint_req = 1'b0;
    check(!phys_en && maint_rvalid, "R7 maint wins", {phys_en, maint_rvalid}, 2'b01);
    check(maint_rdata == {2'b00, exp_present(7), exp_ppn(7)}, "R7 R8 data",
          maint_rdata, {2'b00, exp_present(7), exp_ppn(7)});
    maint(2'd0, 1, '0);
    check(maint_rdata[PPN_W+2:PPN_W+1] == 2'b00, "R7 no status change",
          maint_rdata[PPN_W+2:PPN_W+1], 0);

    // remap a faulting page and access it (R8 write, R1)
    maint(2'd1, 3, {1'b1, 8'hAB});
    cpu_access({LPN_W'(3), 12'hFFF}, 1'b0);
    check(phys_en && phys_addr == {8'hAB, 12'hFFF}, "R1 remap", phys_addr, {8'hAB, 12'hFFF});
    // unmap a page and confirm it now faults (R3)
    maint(2'd1, 5, {1'b0, 8'h00});
    cpu_access({LPN_W'(5), 12'h001}, 1'b0);
    check(fault && !phys_en && fault_lpn == LPN_W'(5), "R3 unmapped", {fault, phys_en}, 2'b10);
    ack_fault();
    check(!fault, "R4 final ack", fault, 0);

    done = 1;
    finish_run();
  end
endmodule